// File: doc/BRIEF.md
# Trace window limit calculator

This block decides how much of a circular trace buffer a trace writer may fill next. Software hands it the consumer state of the ring as three monotonically growing 64-bit byte indices: the current write position (head), the number of free bytes after it, and an index at which the reader wants to be woken. It also supplies the buffer size in pages and the write alignment as a power of two. From these it returns the byte offset at which writing must stop (the limit), how many padding bytes must be inserted at the head before writing, the head index after that padding, and a truncation flag.

Ring offsets are indices taken modulo the buffer size. Before choosing a limit, a misaligned head is padded up to the alignment. The limit is page aligned and never reaches into data the reader has not consumed. A pending wakeup pulls the limit back to the page that follows it. If the resulting window would hold less than a useful minimum run, the gap is padded away and the calculation is repeated once. A snapshot request skips all of this and hands out the whole buffer. The actual padding writes are done elsewhere; the block only reports their length and the fill byte to use.

A request is taken on a one-cycle `start` and answered with a one-cycle `done`. The results stay on the outputs until the next request completes.

Top module: `trace_window_limit`

## Requirements
- R1: After reset `done` and `truncated` are 0, and `limit_off`, `pad_total` and `head_final` are 0.
- R2: The buffer size is `npages` times 2^PAGE_SHIFT bytes, and every ring offset is an index modulo that size, so adding a whole multiple of the buffer size to head and wakeup gives the same limit and padding.
- R3: If the head offset is not a multiple of 2^`align_log2`, padding equal to the distance to the next multiple (but no more than the free length) is added to `pad_total`, and head and free length move by that amount before the rest of the calculation.
- R4: If the free length is zero once alignment is done, the result is limit 0 with `truncated` set.
- R5: If the head offset is below the offset of head plus free length, the limit is that tail offset rounded down to a page boundary; otherwise the limit is the buffer size.
- R6: If the wakeup index is below head plus free length and its offset is at least the head offset, the limit becomes the smaller of the R5 limit and the wakeup offset rounded up to a page boundary.
- R7: If the limit is not above the head offset, all remaining free bytes are added to the padding, `truncated` is set and the limit is 0.
- R8: If a nonzero limit leaves fewer than MIN_RUN (64) bytes after the head offset, that gap is padded and the whole calculation runs a second time on the advanced head; `done` then comes one cycle later than without a rerun.
- R9: With `snapshot` high the limit is the full buffer size, padding is 0, `truncated` is 0 and `head_final` equals the input head.
- R10: With fewer than two pages the request is refused: limit 0, padding 0, `truncated` 1, `head_final` equal to the input head.
- R11: `done` is high for exactly one cycle per accepted request: one clock edge after the capturing edge, or two edges with a rerun; `start` is ignored while a request is in progress.
- R12: `pad_value` is the fill byte 0x70 at all times.
- R13: `head_final` always equals the input head plus `pad_total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; inputs captured on this edge |
| snapshot | input | 1 | Hand out the whole buffer, no calculation |
| npages | input | PAGES_W | Buffer size in pages |
| align_log2 | input | ALIGN_W | Write alignment as log2 bytes |
| head_idx | input | 64 | Monotonic write index |
| free_len | input | 64 | Free bytes after head |
| wake_idx | input | 64 | Monotonic wakeup index |
| done | output | 1 | One-cycle result strobe |
| limit_off | output | 64 | Limit as byte offset from the buffer start |
| pad_total | output | 64 | Total padding bytes to insert at head |
| truncated | output | 1 | Window could not be opened |
| head_final | output | 64 | Head index after padding |
| pad_value | output | 8 | Fill byte for padding |

## Verification
Counting from the edge that samples `start`, a plain, snapshot or refused request shows `done` and its results after one more edge, and a request that needs the minimum-run rerun after two. The bench drives each request at a falling edge, counts falling edges until `done` appears and compares that count with the latency its own arithmetic model predicts, then reads the results at that same falling edge. The sweep covers two buffer sizes, several alignments, head offsets across the whole ring in different wrap generations, free lengths around the minimum run and the page size, and wakeup points behind, inside and beyond the window.

// File: rtl/twl_pkg.sv
package twl_pkg;
  typedef logic [63:0] idx_t;

  typedef struct packed {
    idx_t limit;
    idx_t pad;
    idx_t head;
    idx_t size;
    idx_t hoff;
    logic trunc;
  } pass_t;

  // One window pass: alignment padding, tail round-down, wakeup round-up,
  // and collapse of an empty window.
  function automatic pass_t ring_pass(idx_t hd, idx_t sz, idx_t wk,
                                      idx_t bsz, idx_t pg, idx_t alen);
    pass_t r;
    idx_t  ho, rem, d, to, wo, up, pgmask;
    r      = '0;
    r.head = hd;
    r.size = sz;
    pgmask = ~(pg - 64'd1);
    ho     = hd % bsz;
    rem    = ho & (alen - 64'd1);
    if (rem != 64'd0) begin
      d = alen - rem;
      if (d > sz) d = sz;
      r.head = hd + d;
      r.size = sz - d;
      r.pad  = d;
      ho     = r.head % bsz;
    end
    r.hoff = ho;
    if (r.size == 64'd0) begin
      r.trunc = 1'b1;
      r.limit = 64'd0;
    end else begin
      to      = (r.head + r.size) % bsz;
      wo      = wk % bsz;
      r.limit = bsz;
      if (ho < to) r.limit = to & pgmask;
      if ((wk < r.head + r.size) && (ho <= wo)) begin
        up = (wo + pg - 64'd1) & pgmask;
        if (up < r.limit) r.limit = up;
      end
      if (r.limit <= ho) begin
        r.pad   = r.pad + r.size;
        r.head  = r.head + r.size;
        r.size  = 64'd0;
        r.trunc = 1'b1;
        r.limit = 64'd0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/twl_pass.sv
module twl_pass
  import twl_pkg::*;
(
  input  idx_t  hd,
  input  idx_t  sz,
  input  idx_t  wk,
  input  idx_t  bsz,
  input  idx_t  pg,
  input  idx_t  alen,
  output pass_t res
);
  always_comb res = ring_pass(hd, sz, wk, bsz, pg, alen);
endmodule

// File: rtl/twl_minrun.sv
module twl_minrun
  import twl_pkg::*;
#(
  parameter int MIN_RUN = 64
) (
  input  idx_t limit,
  input  idx_t hoff,
  output logic need,
  output idx_t gap
);
  always_comb begin
    gap  = limit - hoff;
    need = (limit != 64'd0) && (gap < idx_t'(MIN_RUN));
  end
endmodule

// File: rtl/trace_window_limit.sv
module trace_window_limit
  import twl_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int PAGES_W    = 8,
  parameter int ALIGN_W    = 4,
  parameter int MIN_RUN    = 64,
  parameter logic [7:0] FILL_BYTE = 8'h70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               snapshot,
  input  logic [PAGES_W-1:0] npages,
  input  logic [ALIGN_W-1:0] align_log2,
  input  logic [63:0]        head_idx,
  input  logic [63:0]        free_len,
  input  logic [63:0]        wake_idx,
  output logic               done,
  output logic [63:0]        limit_off,
  output logic [63:0]        pad_total,
  output logic               truncated,
  output logic [63:0]        head_final,
  output logic [7:0]         pad_value
);
  localparam idx_t PAGE_BYTES = idx_t'(1) << PAGE_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_P1, S_P2} st_t;
  st_t st;

  idx_t hd_q, sz_q, wk_q, bsz_q, al_q, hd0_q, sz0_q, acc_q, hoff_q;
  logic snap_q, bad_q;

  pass_t pres;
  logic  rerun_need;
  idx_t  rerun_gap;

  twl_pass u_pass (
    .hd(hd_q), .sz(sz_q), .wk(wk_q), .bsz(bsz_q), .pg(PAGE_BYTES), .alen(al_q),
    .res(pres)
  );

  twl_minrun #(.MIN_RUN(MIN_RUN)) u_minrun (
    .limit(pres.limit), .hoff(pres.hoff), .need(rerun_need), .gap(rerun_gap)
  );

  // Named events for the checks below.
  wire ev_accept = (st == S_IDLE) && start;
  wire ev_rerun  = (st == S_P1) && !bad_q && !snap_q && rerun_need;

  assign pad_value = FILL_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hd_q <= '0; sz_q <= '0; wk_q <= '0; bsz_q <= '0; al_q <= 64'd1;
      hd0_q <= '0; sz0_q <= '0; acc_q <= '0; hoff_q <= '0;
      snap_q <= 1'b0; bad_q <= 1'b0;
      done <= 1'b0; limit_off <= '0; pad_total <= '0;
      truncated <= 1'b0; head_final <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (ev_accept) begin
          hd_q   <= head_idx;
          hd0_q  <= head_idx;
          sz_q   <= free_len;
          sz0_q  <= free_len;
          wk_q   <= wake_idx;
          bsz_q  <= idx_t'(npages) << PAGE_SHIFT;
          al_q   <= idx_t'(1) << align_log2;
          snap_q <= snapshot;
          bad_q  <= (npages < PAGES_W'(2));
          acc_q  <= '0;
          st     <= S_P1;
        end
        S_P1: begin
          if (bad_q) begin
            limit_off <= '0; pad_total <= '0; truncated <= 1'b1;
            head_final <= hd_q; hoff_q <= '0;
            done <= 1'b1; st <= S_IDLE;
          end else if (snap_q) begin
            limit_off <= bsz_q; pad_total <= '0; truncated <= 1'b0;
            head_final <= hd_q; hoff_q <= '0;
            done <= 1'b1; st <= S_IDLE;
          end else if (rerun_need) begin
            hd_q  <= pres.head + rerun_gap;
            sz_q  <= pres.size - rerun_gap;
            acc_q <= pres.pad + rerun_gap;
            st    <= S_P2;
          end else begin
            limit_off <= pres.limit; pad_total <= pres.pad;
            truncated <= pres.trunc; head_final <= pres.head;
            hoff_q <= pres.hoff;
            done <= 1'b1; st <= S_IDLE;
          end
        end
        S_P2: begin
          limit_off <= pres.limit; pad_total <= acc_q + pres.pad;
          truncated <= pres.trunc; head_final <= pres.head;
          hoff_q <= pres.hoff;
          done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: done is a single-cycle strobe
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11 / R8: a rerun always finishes on the following edge
  p_rerun_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rerun |=> (st == S_P2));
  p_p2_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_P2) |=> done);
  // R11: an accepted request never completes in the same cycle
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (st == S_P1) && !done);
  // R4 / R7 / R10: a truncated result never opens a window
  p_trunc_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && truncated) |-> (limit_off == 64'd0));
  // R5 / R6: limits land on page boundaries
  p_limit_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (limit_off[PAGE_SHIFT-1:0] == '0));
  // R7: an open window lies beyond the head
  p_limit_past_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !truncated && !snap_q) |-> (limit_off > hoff_q));
  // R3: padding never exceeds the free space offered
  p_pad_in_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pad_total <= sz0_q) || snap_q || bad_q);
  // R13: head moves by exactly the padding
  p_head_adv_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (head_final == hd0_q + pad_total));
  // R9: snapshot hands out the whole buffer
  p_snap_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && snap_q && !bad_q) |-> (limit_off == bsz_q) && !truncated);
endmodule

// File: tb/test_trace_window_limit.sv
module test_trace_window_limit;
  typedef logic [63:0] u64;
  localparam int PSH = 7;
  localparam u64 PG  = u64'(1) << PSH;
  localparam u64 MINR = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, snapshot = 1'b0;
  logic [2:0] npages = 3'd2;
  logic [2:0] align_log2 = 3'd0;
  u64 head_idx = '0, free_len = '0, wake_idx = '0;
  logic done, truncated;
  u64 limit_off, pad_total, head_final;
  logic [7:0] pad_value;

  always #2 clk = ~clk;

  trace_window_limit #(.PAGE_SHIFT(PSH), .PAGES_W(3), .ALIGN_W(3), .MIN_RUN(64))
  i_trace_window_limit (
    .clk(clk), .rst_n(rst_n), .start(start), .snapshot(snapshot),
    .npages(npages), .align_log2(align_log2), .head_idx(head_idx),
    .free_len(free_len), .wake_idx(wake_idx), .done(done),
    .limit_off(limit_off), .pad_total(pad_total), .truncated(truncated),
    .head_final(head_final), .pad_value(pad_value)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input u64 got, input u64 exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic u64 offs(u64 x, u64 b);
    return x - (x / b) * b;
  endfunction

  // One pass of the window rules, written with division arithmetic.
  function automatic void mpass(inout u64 h, inout u64 s, input u64 w, input u64 b,
                                input int al, inout u64 pad, output u64 lim,
                                output bit tr, output u64 ho, inout string tag);
    u64 a, up, to, wo, r, d;
    a  = u64'(1) << al;
    ho = offs(h, b);
    up = ((ho + a - 1) / a) * a;
    tr = 0;
    if (up != ho) begin
      d = up - ho;
      if (d > s) d = s;
      h += d; s -= d; pad += d; tag = "R3";
      ho = offs(h, b);
    end
    if (s == 0) begin
      lim = 0; tr = 1; tag = "R4";
      return;
    end
    to = offs(h + s, b);
    wo = offs(w, b);
    lim = b;
    if (ho < to) begin lim = (to / PG) * PG; tag = "R5"; end
    if (w < h + s && wo >= ho) begin
      r = ((wo + PG - 1) / PG) * PG;
      if (r < lim) begin lim = r; tag = "R6"; end
    end
    if (lim <= ho) begin
      pad += s; h += s; s = 0; tr = 1; lim = 0; tag = "R7";
    end
  endfunction

  function automatic void model(input bit sn, input int np, input int al,
                                input u64 h0, input u64 s0, input u64 w,
                                output u64 lim, output u64 pad, output u64 hout,
                                output bit tr, output int lat, output string tag);
    u64 b, h, s, ho;
    b = u64'(np) * PG; h = h0; s = s0; pad = 0; lat = 2; tag = "R5";
    if (np < 2) begin lim = 0; tr = 1; hout = h0; tag = "R10"; return; end
    if (sn) begin lim = b; tr = 0; hout = h0; tag = "R9"; return; end
    mpass(h, s, w, b, al, pad, lim, tr, ho, tag);
    if (lim != 0 && lim - ho < MINR) begin
      pad += lim - ho; s -= lim - ho; h += lim - ho;
      mpass(h, s, w, b, al, pad, lim, tr, ho, tag);
      lat = 3; tag = {"R8/", tag};
    end
    hout = h;
  endfunction

  task automatic run(input bit sn, input int np, input int al, input u64 h,
                     input u64 s, input u64 w, output int lat);
    @(negedge clk);
    snapshot = sn; npages = 3'(np); align_log2 = 3'(al);
    head_idx = h; free_len = s; wake_idx = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic full(input bit sn, input int np, input int al, input u64 h,
                      input u64 s, input u64 w);
    u64 el, ep, eh; bit et; int elat, lat; string tag;
    model(sn, np, al, h, s, w, el, ep, eh, et, elat, tag);
    run(sn, np, al, h, s, w, lat);
    chk(lat == elat, {tag, " R11 latency"}, u64'(lat), u64'(elat));
    chk(limit_off == el, {tag, " limit"}, limit_off, el);
    chk(pad_total == ep, {tag, " pad"}, pad_total, ep);
    chk(truncated == et, {tag, " truncated"}, u64'(truncated), u64'(et));
    chk(head_final == eh, {tag, " R13 head"}, head_final, eh);
    @(negedge clk);
    chk(!done, "R11 done pulse width", u64'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    u64 l1, p1;
    u64 szs[11];
    longint wds[6];
    szs = '{0, 1, 5, 40, 63, 64, 100, 128, 200, 255, 256};
    wds = '{-10, 0, 30, 90, 200, 1000};

    // R1: reset state
    #1;
    chk(done == 0 && truncated == 0, "R1 flags", u64'({done, truncated}), 0);
    chk(limit_off == 0 && pad_total == 0 && head_final == 0, "R1 values",
        limit_off | pad_total | head_final, 0);
    chk(pad_value == 8'h70, "R12 fill byte", u64'(pad_value), 8'h70);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: same ring position in different wrap generations
    run(0, 3, 0, 5 + 1 * 384, 300, 5 + 1 * 384 + 150, lat);
    l1 = limit_off; p1 = pad_total;
    run(0, 3, 0, 5 + 4 * 384, 300, 5 + 4 * 384 + 150, lat);
    chk(limit_off == l1, "R2 limit across generations", limit_off, l1);
    chk(pad_total == p1, "R2 pad across generations", pad_total, p1);

    // R9, R10 directed
    full(1, 3, 2, 1000, 17, 1001);
    full(1, 2, 0, 3, 0, 0);
    full(0, 1, 0, 40, 100, 60);
    full(0, 0, 3, 41, 0, 0);
    full(1, 1, 0, 7, 7, 7);

    // R11: start while busy is ignored
    begin
      u64 el, ep, eh; bit et; int elat; string tag; int ndone;
      model(0, 2, 0, 256 + 10, 200, 0, el, ep, eh, et, elat, tag);
      @(negedge clk);
      snapshot = 0; npages = 3'd2; align_log2 = 3'd0;
      head_idx = 266; free_len = 200; wake_idx = 0; start = 1'b1;
      @(negedge clk);
      snapshot = 1; npages = 3'd3; head_idx = 9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ndone = 0;
      for (int k = 0; k < 6; k++) begin
        if (done) begin
          ndone++;
          chk(limit_off == el, "R11 busy start ignored limit", limit_off, el);
          chk(head_final == eh, "R11 busy start ignored head", head_final, eh);
        end
        @(negedge clk);
      end
      chk(ndone == 1, "R11 single done", u64'(ndone), 1);
    end

    // Sweep: R3..R8
    for (int np = 2; np <= 3; np++) begin
      for (int ai = 0; ai < 3; ai++) begin
        int al;
        u64 b;
        al = (ai == 0) ? 0 : (ai == 1) ? 3 : 5;
        b = u64'(np) * PG;
        for (u64 ho = 0; ho < b; ho += 13) begin
          for (int si = 0; si < 11; si++) begin
            for (int wi = 0; wi < 6; wi++) begin
              u64 h;
              h = (1 + ho % 3) * b + ho;
              full(0, np, al, h, szs[si], h + u64'(wds[wi]));
            end
          end
        end
      end
    end

    chk(pad_value == 8'h70, "R12 fill byte after use", u64'(pad_value), 8'h70);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule